// File: doc/BRIEF.md
# RAM Access Arbiter

This block shares one 32-bit on-chip static RAM between six peripheral DMA channels and a processor-side bus port. Each DMA channel presents a request with write enable, byte address, access size and write data. The processor port uses a valid/ready handshake. The arbiter picks one owner and performs the access. It then pulses a completion strobe. Read data comes back on the same cycle as that strobe. DMA traffic goes straight to the RAM and never passes through the processor's bus.

The six channels have a fixed ranking, from index 0 (highest) to index 5 (lowest):

| Index | Channel |
|-------|---------|
| 0 | ADC |
| 1 | serial controller 2 receive |
| 2 | serial controller 2 transmit |
| 3 | radio MAC |
| 4 | serial controller 1 receive |
| 5 | serial controller 1 transmit |

A serial controller's receive and transmit channels may both request in the same cycle. DMA outranks the processor. However, the processor is never kept waiting for more than one access in a row.

In normal mode every access completes in the cycle it is granted. When the high-clock-mode input is high at the start of an access, that access takes two wait states and lasts three cycles. The owner keeps its grant for the whole access. A requester holds its request and operands stable until it sees its strobe.

Top module: `sram_access_arb`

## Requirements
- R1: Among requesting DMA channels, the lowest index wins. Index 0 is ADC, 1 is serial 2 receive, 2 is serial 2 transmit, 3 is MAC, 4 is serial 1 receive and 5 is serial 1 transmit.
- R2: When any DMA channel requests at an arbitration point, a DMA channel wins over the processor port, unless R4 applies.
- R3: At an arbitration point with no DMA request and `cpu_valid_i` high, the processor port is served.
- R4: If a DMA access completes while `cpu_valid_i` is high, the next access goes to the processor port, even if DMA requests remain.
- R5: With `hi_clk_i` low when an access starts, grant and done occur in the same cycle. Back-to-back accesses can then complete on consecutive cycles.
- R6: With `hi_clk_i` high when an access starts, the grant lasts three cycles and done pulses only in the third cycle.
- R7: At most one grant is active per cycle. A grant stays with its owner until done, and arbitration happens again only in the following cycle.
- R8: Access size is encoded as 0 for byte, 1 for halfword and 2 or 3 for word. For a byte write, the lane is chosen by address bits [1:0], with lane k being write data bits [8k+7:8k]. The other three bytes of the word are left unchanged.
- R9: A halfword write updates bytes 3:2 when address bit 1 is set, and bytes 1:0 otherwise. Address bit 0 is ignored.
- R10: A word write updates all four bytes, and address bits [1:0] are ignored.
- R11: Read data shows the addressed 32-bit word in the cycle done pulses, for both the processor port and the DMA channels.
- R12: After reset, no grant, done or ready is active until a request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hi_clk_i | input | 1 | High clock mode; adds two wait states per access |
| dma_req_i | input | NCH | Per-channel DMA request |
| dma_we_i | input | NCH | Per-channel write enable |
| dma_addr_i | input | NCH x AW | Per-channel byte address |
| dma_size_i | input | NCH x 2 | Per-channel access size |
| dma_wdata_i | input | NCH x 32 | Per-channel write data, lane positioned |
| dma_gnt_o | output | NCH | Per-channel grant |
| dma_done_o | output | NCH | Per-channel completion strobe |
| dma_rdata_o | output | 32 | Read data for DMA |
| cpu_valid_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | AW | Processor byte address |
| cpu_size_i | input | 2 | Processor access size |
| cpu_wdata_i | input | 32 | Processor write data, lane positioned |
| cpu_ready_o | output | 1 | Processor access completes |
| cpu_rdata_o | output | 32 | Read data for processor |

## Verification
The assertions check the following on every cycle:
- grants are mutually exclusive and held until done;
- no requesting channel outranks the winner;
- the processor loses to DMA only when it is not owed a turn, and is served after a DMA completion it waited through;
- a normal-mode start completes at once, and a high-clock start never completes on its second cycle.

Some behaviour only the directed scenarios can show:
- the full priority walk;
- the exact three-cycle span in high clock mode;
- the byte, halfword and word lane merges, including the ignored address bits;
- the data returned on a read.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  assign gnt_o = req_i & ~(req_i - 1'b1);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/arb_wait_seq.sv
module arb_wait_seq #(
  parameter int WAITS = 2,
  localparam int CW = $clog2(WAITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hi_i,
  output logic busy_o,
  output logic last_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign last_o = busy_q ? (cnt_q == CW'(WAITS)) : (start_i && !hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(WAITS)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i && hi_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end
  end

  assert_first_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && hi_i && !busy_q) |=> (busy_q && !last_o));
endmodule

// File: rtl/arb_lane_decode.sv
module arb_lane_decode
  import sram_arb_pkg::*;
(
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] size_i,
  output logic [3:0] be_o
);
  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: be_o = 4'b0001 << addr_lo_i;
      SZ_HALF: be_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
      default: be_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/arb_sram_store.sv
module arb_sram_store #(
  parameter int DEPTH = 64,
  localparam int WIW = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [3:0]     be_i,
  input  logic [WIW-1:0] idx_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) lane_mem[idx_i] <= wdata_i[8*g +: 8];
    end
    assign rdata_o[8*g +: 8] = lane_mem[idx_i];
  end
endmodule

// File: rtl/sram_access_arb.sv
module sram_access_arb #(
  parameter int NCH   = 6,
  parameter int DEPTH = 64,
  parameter int WAITS = 2,
  localparam int WIW  = $clog2(DEPTH),
  localparam int AW   = WIW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hi_clk_i,
  input  logic [NCH-1:0]       dma_req_i,
  input  logic [NCH-1:0]       dma_we_i,
  input  logic [NCH-1:0][AW-1:0] dma_addr_i,
  input  logic [NCH-1:0][1:0]  dma_size_i,
  input  logic [NCH-1:0][31:0] dma_wdata_i,
  output logic [NCH-1:0]       dma_gnt_o,
  output logic [NCH-1:0]       dma_done_o,
  output logic [31:0]          dma_rdata_o,
  input  logic                 cpu_valid_i,
  input  logic                 cpu_we_i,
  input  logic [AW-1:0]        cpu_addr_i,
  input  logic [1:0]           cpu_size_i,
  input  logic [31:0]          cpu_wdata_i,
  output logic                 cpu_ready_o,
  output logic [31:0]          cpu_rdata_o
);
  localparam int OW     = $clog2(NCH + 1);
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CPU_ID = NCH;

  logic [NCH-1:0] pick_gnt;
  logic [IW-1:0]  pick_idx;
  logic           any_dma, cpu_win, start, busy, last, active, cpu_gnt;
  logic           owed_q;
  logic [OW-1:0]  owner_q, sel_owner, cur_owner;
  logic           m_we;
  logic [AW-1:0]  m_addr;
  logic [1:0]     m_size;
  logic [31:0]    m_wdata, rdata;
  logic [3:0]     be;

  arb_prio_pick #(.N(NCH)) u_pick (
    .req_i (dma_req_i),
    .gnt_o (pick_gnt),
    .idx_o (pick_idx)
  );

  assign any_dma   = |dma_req_i;
  assign cpu_win   = cpu_valid_i && (!any_dma || owed_q);
  assign start     = !busy && (any_dma || cpu_valid_i);
  assign sel_owner = cpu_win ? OW'(CPU_ID) : OW'(pick_idx);
  assign cur_owner = busy ? owner_q : sel_owner;
  assign active    = busy || start;

  arb_wait_seq #(.WAITS(WAITS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hi_i    (hi_clk_i),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      owed_q  <= 1'b0;
    end else begin
      if (start) owner_q <= sel_owner;
      if (last && cur_owner != OW'(CPU_ID) && cpu_valid_i) owed_q <= 1'b1;
      else if (cpu_ready_o) owed_q <= 1'b0;
    end
  end

  always_comb begin
    m_we    = cpu_we_i;
    m_addr  = cpu_addr_i;
    m_size  = cpu_size_i;
    m_wdata = cpu_wdata_i;
    for (int i = 0; i < NCH; i++) begin
      if (cur_owner == OW'(i)) begin
        m_we    = dma_we_i[i];
        m_addr  = dma_addr_i[i];
        m_size  = dma_size_i[i];
        m_wdata = dma_wdata_i[i];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_gnt
    assign dma_gnt_o[g]  = active && (cur_owner == OW'(g));
    assign dma_done_o[g] = dma_gnt_o[g] && last;
  end
  assign cpu_gnt     = active && (cur_owner == OW'(CPU_ID));
  assign cpu_ready_o = cpu_gnt && last;

  arb_lane_decode u_lane (
    .addr_lo_i (m_addr[1:0]),
    .size_i    (m_size),
    .be_o      (be)
  );

  arb_sram_store #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (last && m_we),
    .be_i    (be),
    .idx_i   (m_addr[AW-1:2]),
    .wdata_i (m_wdata),
    .rdata_o (rdata)
  );

  assign dma_rdata_o = rdata;
  assign cpu_rdata_o = rdata;

  assert_onehot_gnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_gnt, dma_gnt_o}));
  assert_hold_gnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_gnt_o && !(|dma_done_o)) |=> $stable(dma_gnt_o));
  assert_prio_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && any_dma && !cpu_gnt) |-> ((dma_req_i & (dma_gnt_o - 1'b1)) == '0));
  assert_dma_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && any_dma && !owed_q) |-> !cpu_gnt);
  assert_cpu_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cpu_valid_i && !any_dma) |-> cpu_gnt);
  assert_no_starve_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_done_o && cpu_valid_i) |=> (!cpu_valid_i || cpu_gnt));
  assert_zero_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && (any_dma || cpu_valid_i) && !hi_clk_i) |-> (|dma_done_o || cpu_ready_o));
endmodule

// File: tb/sim_sram_access_arb.sv
module sim_sram_access_arb;
  localparam int CLK   = 10;
  localparam int NCH   = 6;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_clk = 1'b0;
  logic [NCH-1:0] dma_req = '0, dma_we = '0;
  logic [NCH-1:0][AW-1:0] dma_addr = '0;
  logic [NCH-1:0][1:0] dma_size = '0;
  logic [NCH-1:0][31:0] dma_wdata = '0;
  logic [NCH-1:0] dma_gnt, dma_done;
  logic [31:0] dma_rdata, cpu_rdata;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, cpu_ready;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0] cpu_size = '0;
  logic [31:0] cpu_wdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK/2) clk = ~clk;

  sram_access_arb #(.NCH(NCH), .DEPTH(DEPTH), .WAITS(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hi_clk_i(hi_clk),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr),
    .dma_size_i(dma_size), .dma_wdata_i(dma_wdata),
    .dma_gnt_o(dma_gnt), .dma_done_o(dma_done), .dma_rdata_o(dma_rdata),
    .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_size_i(cpu_size), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after falling edge, sample a quarter period later
  task automatic tick;
    @(negedge clk);
  endtask
  task automatic settle;
    #(CLK/4);
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, input string tag);
    tick();
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    settle();
    chk({tag, " ready"}, 32'(cpu_ready), 32'd1);
    rd = cpu_rdata;
    tick();
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset;
    settle();
    chk("R12 gnt after reset", 32'(dma_gnt), 32'd0);
    chk("R12 done after reset", 32'(dma_done), 32'd0);
    chk("R12 ready after reset", 32'(cpu_ready), 32'd0);
  endtask

  task automatic t_priority;
    tick();
    dma_req = '1; dma_we = '0;
    for (int i = 0; i < NCH; i++) begin
      if (i > 0) begin tick(); dma_req[i-1] = 1'b0; end
      settle();
      chk($sformatf("R1 grant step %0d", i), 32'(dma_gnt), 32'(1 << i));
      chk($sformatf("R5 done step %0d", i), 32'(dma_done), 32'(1 << i));
    end
    tick();
    dma_req = '0;
  endtask

  task automatic t_cpu_idle;
    logic [31:0] rd;
    cpu_op(1'b1, AW'(8'h30), 2'd2, 32'h5555AAAA, rd, "R3 cpu idle write");
    cpu_op(1'b0, AW'(8'h30), 2'd2, 32'h0, rd, "R3 cpu idle read");
    chk("R11 cpu read data", rd, 32'h5555AAAA);
  endtask

  task automatic t_share;
    tick();
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(8'h30);
    dma_req[3] = 1'b1; dma_req[4] = 1'b1;
    settle();
    chk("R2 dma3 beats cpu", 32'(dma_gnt), 32'h08);
    chk("R2 cpu waits", 32'(cpu_ready), 32'd0);
    tick(); dma_req[3] = 1'b0;
    settle();
    chk("R4 cpu after dma", 32'(cpu_ready), 32'd1);
    chk("R4 no dma grant", 32'(dma_gnt), 32'd0);
    tick();
    settle();
    chk("R2 dma4 next", 32'(dma_gnt), 32'h10);
    tick(); dma_req[4] = 1'b0;
    settle();
    chk("R4 cpu again", 32'(cpu_ready), 32'd1);
    tick(); cpu_valid = 1'b0;
  endtask

  task automatic dma_op(input int ch, input logic we, input logic [AW-1:0] a,
                        input logic [1:0] sz, input logic [31:0] wd, input string tag);
    tick();
    dma_req[ch] = 1'b1; dma_we[ch] = we; dma_addr[ch] = a;
    dma_size[ch] = sz; dma_wdata[ch] = wd;
    settle();
    chk({tag, " done"}, 32'(dma_done), 32'(1 << ch));
    tick();
    dma_req[ch] = 1'b0; dma_we[ch] = 1'b0;
  endtask

  task automatic t_lanes;
    logic [31:0] rd;
    cpu_op(1'b1, AW'(8'h10), 2'd2, 32'h11223344, rd, "R10 seed");
    dma_op(5, 1'b1, AW'(8'h12), 2'd0, 32'h00AA0000, "R8 byte write");
    cpu_op(1'b0, AW'(8'h10), 2'd2, 32'h0, rd, "R8 read");
    chk("R8 byte lane 2 merge", rd, 32'h11AA3344);
    cpu_op(1'b1, AW'(8'h13), 2'd1, 32'hBEEF0000, rd, "R9 half write");
    cpu_op(1'b0, AW'(8'h10), 2'd2, 32'h0, rd, "R9 read");
    chk("R9 upper half merge", rd, 32'hBEEF3344);
    dma_op(1, 1'b1, AW'(8'h11), 2'd1, 32'h0000C0DE, "R9 half low write");
    cpu_op(1'b0, AW'(8'h10), 2'd2, 32'h0, rd, "R9 read low");
    chk("R9 lower half merge", rd, 32'hBEEFC0DE);
    cpu_op(1'b1, AW'(8'h17), 2'd3, 32'hCAFEF00D, rd, "R10 word write");
    cpu_op(1'b0, AW'(8'h14), 2'd2, 32'h0, rd, "R10 read");
    chk("R10 word ignores low bits", rd, 32'hCAFEF00D);
  endtask

  task automatic t_high_clock;
    logic [31:0] rd;
    tick();
    hi_clk = 1'b1;
    dma_req[2] = 1'b1; dma_we[2] = 1'b1; dma_addr[2] = AW'(8'h20);
    dma_size[2] = 2'd2; dma_wdata[2] = 32'h0BADF00D;
    settle();
    chk("R6 cycle0 grant", 32'(dma_gnt), 32'h04);
    chk("R6 cycle0 no done", 32'(dma_done), 32'd0);
    tick(); dma_req[0] = 1'b1;
    settle();
    chk("R7 grant held vs higher", 32'(dma_gnt), 32'h04);
    chk("R6 cycle1 no done", 32'(dma_done), 32'd0);
    tick();
    settle();
    chk("R6 cycle2 done", 32'(dma_done), 32'h04);
    tick(); dma_req[2] = 1'b0; dma_we[2] = 1'b0;
    settle();
    chk("R7 rearbitrate to ch0", 32'(dma_gnt), 32'h01);
    chk("R6 ch0 cycle0 no done", 32'(dma_done), 32'd0);
    tick(); tick();
    settle();
    chk("R6 ch0 done third cycle", 32'(dma_done), 32'h01);
    tick(); dma_req[0] = 1'b0; hi_clk = 1'b0;
    cpu_op(1'b0, AW'(8'h20), 2'd2, 32'h0, rd, "R11 read back");
    chk("R11 high clock write data", rd, 32'h0BADF00D);
  endtask

  initial begin
    #(CLK * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_priority();
    t_cpu_idle();
    t_share();
    t_lanes();
    t_high_clock();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule